// File: doc/BRIEF.md
# Narrow/Wide Port Width Adapter

This stage sits between the ports of a FIFO and its storage array, whose entries are 18 bits wide (two 9-bit lanes). The write side and the read side are each set on their own to a narrow (9-bit) or a wide (18-bit) width. A narrow writer delivers lanes one at a time. The stage holds the first lane until its partner arrives, then commits one full entry to storage. A narrow reader takes an entry apart over two reads, and the stage releases the entry from storage only after the second lane has gone out. Because each entry holds two narrow words, the narrow organization stores twice as many words as the wide one.

A byte-order select decides which lane comes first. In big-endian order the first narrow word occupies the upper lane. In little-endian order it occupies the lower lane. The stage captures both widths and the byte order while master reset is held. After that they stay fixed until the next master reset. A partial reset drops a half-built entry and a half-read entry, and it keeps the captured configuration. The stage runs on a single clock. Storage, status flags and clock-domain crossing are outside it.

Top module: `width_match_port`

## Requirements
- R1: Width and byte-order configuration is captured only while rst_n is low; changing the cfg pins after rst_n rises has no effect on packing or unpacking.
- R2: With a wide write side, every wr_en cycle commits wr_data unchanged: st_wr_en is high for exactly the next cycle with st_wr_data equal to that word.
- R3: With a narrow write side in big-endian order (cfg_big_end=1), the committed entry holds the first word in bits 17:9 and the second in bits 8:0.
- R4: With a narrow write side in little-endian order (cfg_big_end=0), the committed entry holds the first word in bits 8:0 and the second in bits 17:9.
- R5: With a narrow write side, the first word of a pair produces no commit; the entry is committed only in the cycle after the second word.
- R6: A partial reset (prst_n low for a cycle) discards a pending first word and a half-read entry, clears st_wr_en and rd_vld, and keeps the captured configuration.
- R7: A master reset discards a pending first word and leaves st_wr_en and rd_vld low.
- R8: With a wide read side, rd_en while st_head_vld is high pops the head (st_pop high in that cycle) and returns the full entry on rd_data with rd_vld high in the next cycle.
- R9: With a narrow read side, the first read of an entry returns bits 17:9 in big-endian order or bits 8:0 in little-endian order, and the second read returns the other lane. The lane sits in rd_data bits 8:0 and bits 17:9 read as zero.
- R10: With a narrow read side, st_pop is high only on the second read of an entry.
- R11: rd_en while st_head_vld is low is ignored: no pop, no rd_vld, and the lane position is unchanged.
- R12: With a narrow write side, wr_data bits 17:9 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, synchronous; configuration is captured while low |
| prst_n | input | 1 | Partial reset, active low, synchronous; keeps configuration |
| cfg_in_wide | input | 1 | 1 = 18-bit write side, 0 = 9-bit |
| cfg_out_wide | input | 1 | 1 = 18-bit read side, 0 = 9-bit |
| cfg_big_end | input | 1 | 1 = first narrow word in upper lane, 0 = lower lane |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 18 | Write word (narrow side uses bits 8:0) |
| st_wr_en | output | 1 | Commit strobe to storage |
| st_wr_data | output | 18 | Committed entry |
| st_head | input | 18 | Entry at the head of storage |
| st_head_vld | input | 1 | Storage holds at least one entry |
| st_pop | output | 1 | Release head entry this cycle |
| rd_en | input | 1 | Read strobe |
| rd_vld | output | 1 | rd_data carries a word read in the previous cycle |
| rd_data | output | 18 | Read word (narrow side in bits 8:0) |

## Verification
The bench covers all eight combinations of widths and byte order. It targets the lone first word of a pair: a design that commits it early would store a half-empty entry, and one that does not clear it on either reset would pair a stale word with fresh data. It reads an empty store in the middle of an entry, where a design that advances its lane pointer anyway would swap the lane order of every later read. It also changes the cfg pins after reset and puts random data in the unused upper bits, which a design that tracks the live pins or keeps those bits would corrupt.

// File: rtl/wmp_pkg.sv
package wmp_pkg;
  typedef struct packed {
    logic in_wide;
    logic out_wide;
    logic big_end;
  } wmp_cfg_t;

  typedef enum logic {
    HALF_FIRST  = 1'b0,
    HALF_SECOND = 1'b1
  } half_e;
endpackage

// File: rtl/wmp_cfg_latch.sv
module wmp_cfg_latch
  import wmp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wmp_cfg_t cfg_pins,
  output wmp_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= cfg_pins;
  end
endmodule

// File: rtl/wmp_pack.sv
module wmp_pack #(
  parameter int LANE_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prst_n,
  input  logic                in_wide,
  input  logic                big_end,
  input  logic                wr_en,
  input  logic [2*LANE_W-1:0] wr_data,
  output logic                st_wr_en,
  output logic [2*LANE_W-1:0] st_wr_data,
  output logic                pending
);
  localparam int ENTRY_W = 2 * LANE_W;

  logic [LANE_W-1:0] first_q;

  function automatic logic [ENTRY_W-1:0] join_lanes(
    input logic [LANE_W-1:0] first,
    input logic [LANE_W-1:0] second,
    input logic              big
  );
    return big ? {first, second} : {second, first};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || !prst_n) begin
      pending    <= 1'b0;
      first_q    <= '0;
      st_wr_en   <= 1'b0;
      st_wr_data <= '0;
    end else begin
      st_wr_en <= 1'b0;
      if (wr_en) begin
        if (in_wide) begin
          st_wr_en   <= 1'b1;
          st_wr_data <= wr_data;
        end else if (!pending) begin
          pending <= 1'b1;
          first_q <= wr_data[LANE_W-1:0];
        end else begin
          pending    <= 1'b0;
          st_wr_en   <= 1'b1;
          st_wr_data <= join_lanes(first_q, wr_data[LANE_W-1:0], big_end);
        end
      end
    end
  end
endmodule

// File: rtl/wmp_unpack.sv
module wmp_unpack
  import wmp_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prst_n,
  input  logic                out_wide,
  input  logic                big_end,
  input  logic                rd_en,
  input  logic [2*LANE_W-1:0] st_head,
  input  logic                st_head_vld,
  output logic                st_pop,
  output logic                rd_vld,
  output logic [2*LANE_W-1:0] rd_data,
  output logic                second_half
);
  localparam int ENTRY_W = 2 * LANE_W;

  half_e half_q;
  logic  take;

  function automatic logic [LANE_W-1:0] pick_lane(
    input logic [ENTRY_W-1:0] entry,
    input logic               second,
    input logic               big
  );
    return (big ^ second) ? entry[ENTRY_W-1:LANE_W] : entry[LANE_W-1:0];
  endfunction

  assign take        = rd_en && st_head_vld;
  assign second_half = (half_q == HALF_SECOND);
  assign st_pop      = take && (out_wide || second_half);

  always_ff @(posedge clk) begin
    if (!rst_n || !prst_n) begin
      half_q  <= HALF_FIRST;
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_vld <= take;
      if (take) begin
        if (out_wide) begin
          rd_data <= st_head;
        end else begin
          rd_data <= {{LANE_W{1'b0}}, pick_lane(st_head, second_half, big_end)};
          half_q  <= second_half ? HALF_FIRST : HALF_SECOND;
        end
      end
    end
  end
endmodule

// File: rtl/width_match_port.sv
module width_match_port
  import wmp_pkg::*;
#(
  parameter int LANE_W  = 9,
  localparam int ENTRY_W = 2 * LANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prst_n,
  input  logic               cfg_in_wide,
  input  logic               cfg_out_wide,
  input  logic               cfg_big_end,
  input  logic               wr_en,
  input  logic [ENTRY_W-1:0] wr_data,
  output logic               st_wr_en,
  output logic [ENTRY_W-1:0] st_wr_data,
  input  logic [ENTRY_W-1:0] st_head,
  input  logic               st_head_vld,
  output logic               st_pop,
  input  logic               rd_en,
  output logic               rd_vld,
  output logic [ENTRY_W-1:0] rd_data
);
  wmp_cfg_t cfg_pins, cfg_q;
  logic     cfg_in_wide_q, cfg_out_wide_q, cfg_big_end_q;
  logic     half_pending, second_half;

  assign cfg_pins = '{in_wide: cfg_in_wide, out_wide: cfg_out_wide, big_end: cfg_big_end};
  assign cfg_in_wide_q  = cfg_q.in_wide;
  assign cfg_out_wide_q = cfg_q.out_wide;
  assign cfg_big_end_q  = cfg_q.big_end;

  wmp_cfg_latch u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_pins (cfg_pins),
    .cfg_q    (cfg_q)
  );

  wmp_pack #(.LANE_W(LANE_W)) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .prst_n     (prst_n),
    .in_wide    (cfg_in_wide_q),
    .big_end    (cfg_big_end_q),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .st_wr_en   (st_wr_en),
    .st_wr_data (st_wr_data),
    .pending    (half_pending)
  );

  wmp_unpack #(.LANE_W(LANE_W)) u_unpack (
    .clk         (clk),
    .rst_n       (rst_n),
    .prst_n      (prst_n),
    .out_wide    (cfg_out_wide_q),
    .big_end     (cfg_big_end_q),
    .rd_en       (rd_en),
    .st_head     (st_head),
    .st_head_vld (st_head_vld),
    .st_pop      (st_pop),
    .rd_vld      (rd_vld),
    .rd_data     (rd_data),
    .second_half (second_half)
  );
endmodule

// File: rtl/width_match_port_chk.sv
module width_match_port_chk #(
  parameter int LANE_W = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic                prst_n,
  input logic                wr_en,
  input logic [2*LANE_W-1:0] wr_data,
  input logic                st_wr_en,
  input logic [2*LANE_W-1:0] st_wr_data,
  input logic                st_pop,
  input logic                st_head_vld,
  input logic                rd_en,
  input logic                rd_vld,
  input logic                cfg_in_wide_q,
  input logic                cfg_out_wide_q,
  input logic                cfg_big_end_q,
  input logic                half_pending,
  input logic                second_half
);
  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable({cfg_in_wide_q, cfg_out_wide_q, cfg_big_end_q}));

  p_wide_commit_r2: assert property (@(posedge clk) disable iff (!rst_n || !prst_n)
    (cfg_in_wide_q && wr_en) |=> (st_wr_en && st_wr_data == $past(wr_data)));

  p_first_half_held_r5: assert property (@(posedge clk) disable iff (!rst_n || !prst_n)
    (!cfg_in_wide_q && wr_en && !half_pending) |=> (!st_wr_en && half_pending));

  p_prst_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !prst_n |=> (!half_pending && !second_half && !st_wr_en && !rd_vld));

  p_read_ack_r8: assert property (@(posedge clk) disable iff (!rst_n || !prst_n)
    (rd_en && st_head_vld) |=> rd_vld);

  p_narrow_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_pop && !cfg_out_wide_q) |-> second_half);

  p_pop_needs_head_r11: assert property (@(posedge clk) disable iff (!rst_n)
    st_pop |-> st_head_vld);

  p_idle_read_r11: assert property (@(posedge clk) disable iff (!rst_n || !prst_n)
    (!(rd_en && st_head_vld)) |=> (!rd_vld && $stable(second_half)));
endmodule

bind width_match_port width_match_port_chk #(.LANE_W(LANE_W)) u_chk (.*);

// File: tb/tb_width_match_port.sv
module tb_width_match_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, prst_n = 1'b1;
  logic        cfg_in_wide = 1'b0, cfg_out_wide = 1'b0, cfg_big_end = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [17:0] wr_data = '0;
  logic        st_wr_en, st_pop, rd_vld;
  logic [17:0] st_wr_data, rd_data, st_head;
  logic        st_head_vld;

  logic [17:0] mem [64];
  int          wp = 0, rp = 0;
  assign st_head_vld = (wp != rp);
  assign st_head     = mem[rp % 64];

  bit       m_in, m_out, m_big, m_pend, m_half;
  bit [8:0] m_first;
  int       vectors = 0, fails = 0;

  always #10 clk = ~clk;

  width_match_port dut (.*);

  function automatic bit [17:0] exp_join(bit [8:0] a, bit [8:0] b, bit big);
    return big ? {a, b} : {b, a};
  endfunction

  function automatic bit [8:0] exp_lane(bit [17:0] e, bit sec, bit big);
    bit upper = big ? !sec : sec;
    return upper ? e[17:9] : e[8:0];
  endfunction

  task automatic chk(bit ok, string req, logic [17:0] act, logic [17:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // R1 R7: capture config in reset, then scramble the pins
  task automatic do_rst(bit iw, bit ow, bit be);
    @(negedge clk);
    rst_n = 1'b0; prst_n = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    cfg_in_wide = iw; cfg_out_wide = ow; cfg_big_end = be;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_in = iw; m_out = ow; m_big = be; m_pend = 0; m_half = 0;
    wp = 0; rp = 0;
    cfg_in_wide = !iw; cfg_out_wide = !ow; cfg_big_end = !be;
    #1 chk(!st_wr_en && !rd_vld, "R7 outputs after reset", {st_wr_en, rd_vld}, 0);
  endtask

  task automatic do_prst();
    @(negedge clk);
    prst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    @(posedge clk); #1;
    chk(!st_wr_en && !rd_vld, "R6 outputs after partial reset", {st_wr_en, rd_vld}, 0);
    m_pend = 0; m_half = 0;
    @(negedge clk);
    prst_n = 1'b1;
  endtask

  task automatic step(bit w, bit [17:0] wd, bit r);
    bit        ecommit, eread, epop;
    bit [17:0] edata, erd, head;
    @(negedge clk);
    wr_en = w; wr_data = wd; rd_en = r;
    ecommit = 0; edata = '0; epop = 0; erd = '0;
    if (w) begin
      if (m_in) begin ecommit = 1; edata = wd; end
      else if (!m_pend) begin m_pend = 1; m_first = wd[8:0]; end
      else begin ecommit = 1; edata = exp_join(m_first, wd[8:0], m_big); m_pend = 0; end
    end
    eread = r && (wp != rp);
    if (eread) begin
      head = mem[rp % 64];
      if (m_out) begin erd = head; epop = 1; end
      else begin erd = {9'b0, exp_lane(head, m_half, m_big)}; epop = m_half; m_half = !m_half; end
    end
    #5;
    chk(st_pop == epop, !st_head_vld ? "R11 pop on empty" : (m_out ? "R8 pop" : "R10 pop"),
        18'(st_pop), 18'(epop));
    @(posedge clk); #1;
    if (ecommit)
      chk(st_wr_en && st_wr_data == edata,
          m_in ? "R2 commit" : (m_big ? "R3 R12 commit" : "R4 R12 commit"), st_wr_data, edata);
    else
      chk(!st_wr_en, "R5 no commit", 18'(st_wr_en), 0);
    if (ecommit) begin mem[wp % 64] = edata; wp++; end
    if (eread)
      chk(rd_vld && rd_data == erd, m_out ? "R8 read" : "R9 read", rd_data, erd);
    else
      chk(!rd_vld, "R11 idle read", 18'(rd_vld), 0);
    if (epop) rp++;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_0417));

    // R3 R1: narrow in, big-endian, pins flipped to wide after reset
    do_rst(0, 0, 1);
    step(1, 18'h3_F1A5 & 18'h3FFFF, 0);
    chk(!st_wr_en, "R1 latched narrow width kept", 18'(st_wr_en), 0);
    step(1, 18'h2A05C, 0);
    chk(st_wr_data == {9'h1A5, 9'h05C}, "R3 upper lane first", st_wr_data, {9'h1A5, 9'h05C});
    // R11: read mid-entry then empty store, order kept
    step(0, 0, 1);
    step(0, 0, 1);
    step(0, 0, 1);
    // R4 little-endian directed
    do_rst(0, 1, 0);
    step(1, 18'h00011, 0);
    step(1, 18'h3FF22, 0);
    chk(st_wr_data == {9'h122, 9'h011}, "R4 lower lane first", st_wr_data, {9'h122, 9'h011});
    step(0, 0, 1);
    // R6: pending half dropped by partial reset
    do_rst(0, 0, 1);
    step(1, 18'h000AA, 0);
    do_prst();
    step(1, 18'h00033, 0);
    step(1, 18'h00044, 0);
    chk(st_wr_data == {9'h033, 9'h044}, "R6 stale half dropped", st_wr_data, {9'h033, 9'h044});
    // R7: pending half dropped by master reset
    step(1, 18'h00055, 0);
    do_rst(0, 0, 1);
    step(1, 18'h00066, 0);
    step(1, 18'h00077, 0);
    chk(st_wr_data == {9'h066, 9'h077}, "R7 stale half dropped", st_wr_data, {9'h066, 9'h077});

    // random traffic over every configuration
    for (int c = 0; c < 8; c++) begin
      do_rst(c[2], c[1], c[0]);
      for (int i = 0; i < 150; i++) begin
        bit w = ($urandom % 2 == 1) && ((wp - rp) < 56);
        bit r = ($urandom % 3 != 0);
        if ($urandom % 40 == 0) do_prst();
        else step(w, 18'($urandom), r);
      end
    end
    summary();
  end
endmodule